// File: doc/BRIEF.md
# Fast-Lock Window Sequencer

This block sits behind the register write port of a fractional-N synthesizer. It decodes 24-bit register words and keeps the state that a timed wide-bandwidth acquisition mode needs. One 12-bit field in the reference-divider word serves two purposes. A control bit in the same word decides whether the field is the modulus or the length of the wide-bandwidth window.

The reference-divider word also carries a 3-bit output-multiplexer code. Fast-lock needs the code 110 in that field. Once the window length has been loaded and that code is in place, the block treats the setup as complete. From then on, each write of the feedback-divider word with its fast-lock bit set starts a window. The window runs for the stored number of phase-detector cycles, which arrive as single-cycle pulses on `pfd_tick`. While the window runs, `wide_bw_o` is held high. Later frequency jumps need only that one feedback-divider write.

Top module: `flk_sequencer`

## Requirements
- R1: During and right after a synchronous reset, `modulus_o`, `fl_timer_o` and `mux_sel_o` are all zero, and `setup_ok_o` and `wide_bw_o` are low.
- R2: Bits 1:0 of a written word select its target: 01 is the reference divider, 00 the feedback divider, 10 the control register and 11 the noise/spur register. A write to the control or noise/spur register changes none of the outputs.
- R3: A reference-divider write with bit 23 at 1 puts bits 13:2 on `fl_timer_o` one cycle later. `modulus_o` and `mux_sel_o` stay unchanged.
- R4: A reference-divider write with bit 23 at 0 puts bits 13:2 on `modulus_o` and bits 22:20 on `mux_sel_o` one cycle later. `fl_timer_o` stays unchanged.
- R5: `setup_ok_o` is high exactly when at least one timer load (R3) has taken place since reset and `mux_sel_o` holds 110. It changes in the same cycle as those outputs.
- R6: A feedback-divider write with bit 23 at 1 is a trigger. A trigger accepted while `setup_ok_o` is high and `fl_timer_o` is nonzero raises `wide_bw_o` in the next cycle. `wide_bw_o` then stays high until the T-th `pfd_tick` pulse after the trigger cycle has been sampled, where T is the stored timer value. A tick that arrives in the trigger cycle itself is not counted.
- R7: A trigger accepted while a window is running reloads the full stored timer value, so the window is extended.
- R8: When the stored timer value is zero, a trigger opens no window.
- R9: A trigger issued while `setup_ok_o` is low is ignored, and so is a feedback-divider write with bit 23 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register word valid this cycle |
| wr_word | input | 24 | Register word; bits 1:0 select the register |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector period |
| modulus_o | output | 12 | Stored fractional modulus |
| fl_timer_o | output | 12 | Stored window length in phase-detector periods |
| mux_sel_o | output | 3 | Stored output-multiplexer code |
| setup_ok_o | output | 1 | Timer loaded and multiplexer code is 110 |
| wide_bw_o | output | 1 | Wide-bandwidth window active |

## Verification
All stored fields and the setup flag are due one cycle after the rising edge that samples the write. The window output rises in that same cycle, and it falls at the edge that samples the T-th counted tick. The bench drives inputs just after each falling edge. A behavioural model updates at each rising edge, and all outputs are compared with the model at the next falling edge, so every result is read in the cycle it is due. Directed checks also sample the window at the cycle where an unextended window would have closed, and they count the high cycles of a complete window with ticks on every clock.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [1:0] {
    SEL_NDIV  = 2'b00,
    SEL_RDIV  = 2'b01,
    SEL_CTRL  = 2'b10,
    SEL_SPUR  = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic rdiv_timer;   // reference-divider word carrying a window length
    logic rdiv_normal;  // reference-divider word carrying modulus and mux code
    logic ndiv_fast;    // feedback-divider word with fast-lock request
  } wr_strobe_t;

endpackage

// File: rtl/flk_reg_decode.sv
module flk_reg_decode
  import flk_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int FIELD_W   = 12,
  parameter int FIELD_LSB = 2,
  parameter int MUX_W     = 3,
  parameter int MUX_LSB   = 20,
  parameter int CTL_BIT   = 23
) (
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  output wr_strobe_t         strobe,
  output logic [FIELD_W-1:0] field,
  output logic [MUX_W-1:0]   mux_code
);

  localparam int SEL_W = 2;

  reg_sel_e  sel;
  logic      ctl;
  logic      unused_bits;

  always_comb begin
    sel      = reg_sel_e'(wr_word[SEL_W-1:0]);
    ctl      = wr_word[CTL_BIT];
    field    = wr_word[FIELD_LSB +: FIELD_W];
    mux_code = wr_word[MUX_LSB +: MUX_W];

    strobe             = '0;
    strobe.rdiv_timer  = wr_en && (sel == SEL_RDIV) &&  ctl;
    strobe.rdiv_normal = wr_en && (sel == SEL_RDIV) && !ctl;
    strobe.ndiv_fast   = wr_en && (sel == SEL_NDIV) &&  ctl;
  end

  // control and noise/spur words carry nothing this block keeps
  assign unused_bits = ^wr_word;

endmodule

// File: rtl/flk_setup_store.sv
module flk_setup_store
  import flk_pkg::*;
#(
  parameter int              FIELD_W = 12,
  parameter int              MUX_W   = 3,
  parameter logic [MUX_W-1:0] MUX_FL = 3'b110
) (
  input  logic               clk,
  input  logic               rst,
  input  wr_strobe_t         strobe,
  input  logic [FIELD_W-1:0] field,
  input  logic [MUX_W-1:0]   mux_code,
  output logic [FIELD_W-1:0] modulus_q,
  output logic [FIELD_W-1:0] timer_q,
  output logic [MUX_W-1:0]   mux_q,
  output logic               setup_ok_q
);

  logic               timer_seen_q;
  logic               timer_seen_d;
  logic [FIELD_W-1:0] modulus_d;
  logic [FIELD_W-1:0] timer_d;
  logic [MUX_W-1:0]   mux_d;

  always_comb begin
    modulus_d    = modulus_q;
    timer_d      = timer_q;
    mux_d        = mux_q;
    timer_seen_d = timer_seen_q;
    if (strobe.rdiv_timer) begin
      timer_d      = field;
      timer_seen_d = 1'b1;
    end
    if (strobe.rdiv_normal) begin
      modulus_d = field;
      mux_d     = mux_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modulus_q    <= '0;
      timer_q      <= '0;
      mux_q        <= '0;
      timer_seen_q <= 1'b0;
      setup_ok_q   <= 1'b0;
    end else begin
      modulus_q    <= modulus_d;
      timer_q      <= timer_d;
      mux_q        <= mux_d;
      timer_seen_q <= timer_seen_d;
      setup_ok_q   <= timer_seen_d && (mux_d == MUX_FL);
    end
  end

endmodule

// File: rtl/flk_window_timer.sv
module flk_window_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_req,
  input  logic             setup_ok,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             wide_q
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             accept;

  always_comb begin
    accept  = arm_req && setup_ok && (load_val != '0);
    count_d = count_q;
    if (accept) begin
      count_d = load_val;
    end else if (tick && (count_q != '0)) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      wide_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      wide_q  <= (count_d != '0);
    end
  end

endmodule

// File: rtl/flk_sequencer.sv
module flk_sequencer
  import flk_pkg::*;
#(
  parameter int               WORD_W    = 24,
  parameter int               FIELD_W   = 12,
  parameter int               FIELD_LSB = 2,
  parameter int               MUX_W     = 3,
  parameter int               MUX_LSB   = 20,
  parameter int               CTL_BIT   = 23,
  parameter logic [MUX_W-1:0] MUX_FL    = 3'b110
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               pfd_tick,
  output logic [FIELD_W-1:0] modulus_o,
  output logic [FIELD_W-1:0] fl_timer_o,
  output logic [MUX_W-1:0]   mux_sel_o,
  output logic               setup_ok_o,
  output logic               wide_bw_o
);

  wr_strobe_t         strobe;
  logic [FIELD_W-1:0] field;
  logic [MUX_W-1:0]   mux_code;

  flk_reg_decode #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
    .MUX_W(MUX_W), .MUX_LSB(MUX_LSB), .CTL_BIT(CTL_BIT)
  ) u_decode (
    .wr_en(wr_en), .wr_word(wr_word),
    .strobe(strobe), .field(field), .mux_code(mux_code)
  );

  flk_setup_store #(
    .FIELD_W(FIELD_W), .MUX_W(MUX_W), .MUX_FL(MUX_FL)
  ) u_store (
    .clk(clk), .rst(rst), .strobe(strobe), .field(field), .mux_code(mux_code),
    .modulus_q(modulus_o), .timer_q(fl_timer_o), .mux_q(mux_sel_o),
    .setup_ok_q(setup_ok_o)
  );

  flk_window_timer #(
    .CNT_W(FIELD_W)
  ) u_window (
    .clk(clk), .rst(rst), .arm_req(strobe.ndiv_fast), .setup_ok(setup_ok_o),
    .load_val(fl_timer_o), .tick(pfd_tick), .wide_q(wide_bw_o)
  );

endmodule

// File: rtl/flk_sequencer_chk.sv
module flk_sequencer_chk #(
  parameter int               WORD_W    = 24,
  parameter int               FIELD_W   = 12,
  parameter int               FIELD_LSB = 2,
  parameter int               MUX_W     = 3,
  parameter int               MUX_LSB   = 20,
  parameter int               CTL_BIT   = 23,
  parameter logic [MUX_W-1:0] MUX_FL    = 3'b110
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [WORD_W-1:0]  wr_word,
  input logic               pfd_tick,
  input logic [FIELD_W-1:0] modulus_o,
  input logic [FIELD_W-1:0] fl_timer_o,
  input logic [MUX_W-1:0]   mux_sel_o,
  input logic               setup_ok_o,
  input logic               wide_bw_o
);

  logic r_wr, n_wr, side_wr;
  assign r_wr    = wr_en && (wr_word[1:0] == 2'b01);
  assign n_wr    = wr_en && (wr_word[1:0] == 2'b00);
  assign side_wr = wr_en && wr_word[1];

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!wide_bw_o && !setup_ok_o && fl_timer_o == '0 && modulus_o == '0 && mux_sel_o == '0));

  a_r2_side_regs_inert: assert property (@(posedge clk) disable iff (rst)
    side_wr |=> ($stable(modulus_o) && $stable(fl_timer_o) && $stable(mux_sel_o) && $stable(setup_ok_o)));

  a_r3_timer_capture: assert property (@(posedge clk) disable iff (rst)
    (r_wr && wr_word[CTL_BIT]) |=> (fl_timer_o == $past(wr_word[FIELD_LSB +: FIELD_W])
                                    && $stable(modulus_o) && $stable(mux_sel_o)));

  a_r4_modulus_capture: assert property (@(posedge clk) disable iff (rst)
    (r_wr && !wr_word[CTL_BIT]) |=> (modulus_o == $past(wr_word[FIELD_LSB +: FIELD_W])
                                     && mux_sel_o == $past(wr_word[MUX_LSB +: MUX_W])
                                     && $stable(fl_timer_o)));

  a_r5_setup_needs_mux: assert property (@(posedge clk) disable iff (rst)
    setup_ok_o |-> (mux_sel_o == MUX_FL));

  a_r6_window_opens: assert property (@(posedge clk) disable iff (rst)
    (n_wr && wr_word[CTL_BIT] && setup_ok_o && fl_timer_o != '0) |=> wide_bw_o);

  a_r6_window_holds: assert property (@(posedge clk) disable iff (rst)
    (wide_bw_o && !pfd_tick) |=> wide_bw_o);

  a_r8_zero_timer: assert property (@(posedge clk) disable iff (rst)
    (fl_timer_o == '0 && !wide_bw_o) |=> !wide_bw_o);

  a_r9_no_setup_ignored: assert property (@(posedge clk) disable iff (rst)
    (!setup_ok_o && !wide_bw_o) |=> !wide_bw_o);

endmodule

bind flk_sequencer flk_sequencer_chk #(
  .WORD_W(WORD_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
  .MUX_W(MUX_W), .MUX_LSB(MUX_LSB), .CTL_BIT(CTL_BIT), .MUX_FL(MUX_FL)
) chk_i (.*);

// File: tb/flk_sequencer_tb_top.sv
module flk_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_word = '0;
  logic        pfd_tick = 1'b0;
  logic [11:0] modulus_o, fl_timer_o;
  logic [2:0]  mux_sel_o;
  logic        setup_ok_o, wide_bw_o;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int cyc = 0;
  string phase = "R1";

  // behavioural reference state
  int m_mod = 0, m_tim = 0, m_mux = 0, m_cnt = 0;
  bit m_loaded = 0, m_setup = 0, m_wide = 0;

  always #4 clk = ~clk;

  flk_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .pfd_tick(pfd_tick),
    .modulus_o(modulus_o), .fl_timer_o(fl_timer_o), .mux_sel_o(mux_sel_o),
    .setup_ok_o(setup_ok_o), .wide_bw_o(wide_bw_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_mod = 0; m_tim = 0; m_mux = 0; m_cnt = 0;
      m_loaded = 0; m_setup = 0; m_wide = 0;
    end else begin
      bit fire;
      fire = wr_en && wr_word[1:0] == 2'b00 && wr_word[23] && m_setup && m_tim != 0;
      if (wr_en && wr_word[1:0] == 2'b01) begin
        if (wr_word[23]) begin
          m_tim = int'(wr_word[13:2]); m_loaded = 1;
        end else begin
          m_mod = int'(wr_word[13:2]); m_mux = int'(wr_word[22:20]);
        end
      end
      if (fire) m_cnt = m_tim;
      else if (pfd_tick && m_cnt > 0) m_cnt = m_cnt - 1;
      m_setup = m_loaded && (m_mux == 6);
      m_wide = (m_cnt != 0);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (phase %s): actual %0d expected %0d", req, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 modulus", int'(modulus_o), m_mod);
      chk("R3 timer", int'(fl_timer_o), m_tim);
      chk("R4 mux", int'(mux_sel_o), m_mux);
      chk("R5 setup", int'(setup_ok_o), int'(m_setup));
      chk("R6 window", int'(wide_bw_o), int'(m_wide));
    end
  end

  // tick generator: drives after the falling edge
  always @(negedge clk) begin
    #1;
    cyc++;
    pfd_tick <= (tick_div > 0) && (cyc % tick_div == 0);
  end

  task automatic wr(logic [23:0] w);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_word = w;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_word = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [23:0] rword(bit ctl, logic [2:0] mux, logic [11:0] f);
    return {ctl, mux, 6'h00, f, 2'b01};
  endfunction

  function automatic logic [23:0] nword(bit fast);
    return {fast, 9'h0A5, 12'h3C1, 2'b00};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int hi;
    repeat (3) @(negedge clk);
    #1; rst = 1'b0;
    idle(1);
    phase = "R1";
    chk("R1 reset wide", int'(wide_bw_o), 0);
    chk("R1 reset setup", int'(setup_ok_o), 0);
    chk("R1 reset timer", int'(fl_timer_o), 0);

    phase = "R9";
    wr(nword(1));
    chk("R9 trigger before setup", int'(wide_bw_o), 0);
    idle(2);

    phase = "R3";
    wr(rword(1, 3'b010, 12'd5));
    chk("R3 timer loaded", int'(fl_timer_o), 5);
    chk("R3 mux untouched", int'(mux_sel_o), 0);

    phase = "R2";
    wr(24'hFFFFFE);
    wr(24'h5A5A5F);
    chk("R2 side writes inert", int'(fl_timer_o), 5);
    chk("R2 side writes inert mod", int'(modulus_o), 0);

    phase = "R4";
    wr(rword(0, 3'b110, 12'd130));
    chk("R4 modulus", int'(modulus_o), 130);
    chk("R5 setup after mux", int'(setup_ok_o), 1);

    phase = "R6";
    tick_div = 1;
    wr(nword(1));
    hi = 0;
    while (wide_bw_o) begin hi++; idle(1); end
    chk("R6 window length", hi, 5);

    phase = "R7";
    wr(nword(1));
    idle(1);
    wr(nword(1));
    idle(2);
    chk("R7 extended past first window", int'(wide_bw_o), 1);
    idle(8);

    phase = "R9";
    wr(nword(0));
    chk("R9 n write without fast bit", int'(wide_bw_o), 0);

    phase = "R8";
    wr(rword(1, 3'b000, 12'd0));
    wr(nword(1));
    chk("R8 zero timer", int'(wide_bw_o), 0);
    idle(2);

    phase = "R6";
    tick_div = 3;
    wr(rword(1, 3'b000, 12'd4));
    wr(nword(1));
    idle(20);

    phase = "R5";
    wr(rword(0, 3'b001, 12'd65));
    chk("R5 setup drops", int'(setup_ok_o), 0);
    wr(nword(1));
    chk("R9 trigger after setup lost", int'(wide_bw_o), 0);
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule